// File: doc/BRIEF.md
# CPU-Bus FIFO Bridge with Status

This block joins an asynchronous, byte-wide microprocessor bus to a pair of byte FIFOs. Received bytes enter one FIFO through a valid/ready stream. Bytes written by the processor collect in the other FIFO and leave through a second valid/ready stream. The processor selects the block with an active-low chip select and uses a single address bit. Address 0 carries data in both directions. Address 1 returns a status byte on reads. A write to address 1 raises a flush request, which tells the packet side to send whatever transmit data is buffered without waiting for a full packet.

The bus pins are not related to the block clock. Every control pin and the data bus pass through two-flop synchronisers. A read latches its return value when the read strobe falls, so the value stays steady while the strobe is low. Each access takes effect once, when its strobe rises. The block drives the data bus only while chip select and read are both low at the pins, and leaves it high-impedance at all other times.

Top module: `cpubus_fifo_bridge`

## Requirements
- R1: While bus_cs_n is 1, strobes cause no FIFO, flush or overflow change, and bus_data is not driven. It reads as the bench pull-up value 0xFF.
- R2: A read at address 1 returns a status byte. Bit 0 is 1 when the receive FIFO holds at least one byte. Bit 1 is 1 when the transmit FIFO has room for at least one byte. Bits 7 to 2 are 0.
- R3: A read at address 0 returns the oldest received byte and removes it from the receive FIFO. Bytes come out in arrival order.
- R4: A read at address 0 while the receive FIFO is empty at the read's falling edge returns 0x00 and removes nothing. This holds even if a byte arrives before the strobe rises.
- R5: A write at address 0 appends the bus byte to the transmit FIFO. Bytes appear on tx_data/tx_valid in write order and leave on each cycle with tx_valid and tx_ready both high.
- R6: A write at address 0 while the transmit FIFO is full is discarded and sets tx_overflow. tx_overflow then stays 1 until reset.
- R7: A write at address 1 sets flush_req to 1 and leaves the transmit FIFO unchanged, whatever the written data.
- R8: flush_req stays 1 until a cycle with flush_ack high clears it. If a new flush write takes effect in the same cycle as flush_ack, flush_req stays 1.
- R9: rx_ready is 1 exactly when the receive FIFO has room. A byte is accepted on each cycle with rx_valid and rx_ready both high.
- R10: An access acts exactly once however long its strobe is held. The read value on bus_data stays constant for the whole time the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_addr | input | 1 | Register select: 0 data, 1 status/flush |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_data | inout | 8 | Bidirectional data bus |
| tx_data | output | 8 | Transmit stream byte (head of transmit FIFO) |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_ready | input | 1 | Downstream accepts transmit byte |
| rx_data | input | 8 | Receive stream byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive FIFO has room |
| flush_req | output | 1 | Send buffered transmit data now |
| flush_ack | input | 1 | Single-cycle acknowledge of flush_req |
| tx_overflow | output | 1 | Sticky: a transmit write was discarded |

## Verification
Two events can collide in one cycle. The first is a flush write that takes effect in the same cycle as a flush_ack pulse. The bench counts the synchroniser and edge-detect stages to hit the cycle in which the write's rising edge is acted on, and it raises flush_ack in exactly that cycle. flush_req must remain 1 afterwards, and a later lone acknowledge must clear it. The second case is a receive byte that arrives while a data read of an empty receive FIFO is in progress. The read must still return 0x00, and the new byte must stay queued for the next read. Status sweeps step the transmit fill level from empty to full and compare each status byte with a value computed from that level.

// File: rtl/cpubus_bridge_pkg.sv
package cpubus_bridge_pkg;

  localparam int BYTE_W      = 8;
  localparam int STAT_RX_BIT = 0;
  localparam int STAT_TX_BIT = 1;

  typedef struct packed {
    logic              cs_n;
    logic              addr;
    logic              rd_n;
    logic              wr_n;
    logic [BYTE_W-1:0] data;
  } bus_sample_t;

  localparam int SAMPLE_W = $bits(bus_sample_t);

endpackage

// File: rtl/cpubus_sync.sv
module cpubus_sync #(
  parameter int               WIDTH   = 4,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign d_sync = stage2;

endmodule

// File: rtl/cpubus_byte_fifo.sv
module cpubus_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);

  localparam int             AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int             CW       = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]  LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0]  FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, wptr_d;
  logic [AW-1:0]    rptr, rptr_d;
  logic [CW-1:0]    cnt, cnt_d;
  logic             push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_CNT);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rptr];

  always_comb begin
    wptr_d = wptr;
    rptr_d = rptr;
    cnt_d  = cnt;
    if (push_ok) wptr_d = (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
    if (pop_ok)  rptr_d = (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt + 1'b1;
      2'b01:   cnt_d = cnt - 1'b1;
      default: cnt_d = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      wptr <= wptr_d;
      rptr <= rptr_d;
      cnt  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  // R6: a push into a full FIFO without a pop leaves the fill level as it was
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt));

  // R4: a pop of an empty FIFO leaves it empty unless a push arrives
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);

endmodule

// File: rtl/cpubus_access.sv
module cpubus_access
  import cpubus_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_sample_t       smp,
  input  logic              rx_empty,
  input  logic [BYTE_W-1:0] rx_head,
  input  logic              tx_full,
  output logic              rx_pop,
  output logic              tx_push,
  output logic [BYTE_W-1:0] tx_wdata,
  output logic              ovf_set,
  output logic              flush_set,
  output logic [BYTE_W-1:0] rd_value
);

  logic              rd_q, wr_q;
  logic              rd_sel, rd_sel_d;
  logic              rd_addr, rd_addr_d;
  logic              rd_hit, rd_hit_d;
  logic              wr_sel, wr_sel_d;
  logic              wr_addr, wr_addr_d;
  logic [BYTE_W-1:0] wr_dat, wr_dat_d;
  logic [BYTE_W-1:0] rd_latch, rd_latch_d;
  logic [BYTE_W-1:0] status;
  logic              rd_fall, rd_rise, wr_rise;

  assign rd_fall = rd_q && !smp.rd_n;
  assign rd_rise = !rd_q && smp.rd_n;
  assign wr_rise = !wr_q && smp.wr_n;

  always_comb begin
    status              = '0;
    status[STAT_RX_BIT] = !rx_empty;
    status[STAT_TX_BIT] = !tx_full;
  end

  always_comb begin
    rd_sel_d   = rd_sel;
    rd_addr_d  = rd_addr;
    rd_hit_d   = rd_hit;
    rd_latch_d = rd_latch;
    if (rd_fall) begin
      rd_sel_d  = !smp.cs_n;
      rd_addr_d = smp.addr;
      rd_hit_d  = !rx_empty;
      if (!smp.cs_n) begin
        if (smp.addr)      rd_latch_d = status;
        else if (rx_empty) rd_latch_d = '0;
        else               rd_latch_d = rx_head;
      end
    end
    if (rd_rise) rd_sel_d = 1'b0;
  end

  always_comb begin
    wr_sel_d  = wr_sel;
    wr_addr_d = wr_addr;
    wr_dat_d  = wr_dat;
    if (!smp.wr_n) begin
      wr_sel_d  = !smp.cs_n;
      wr_addr_d = smp.addr;
      wr_dat_d  = smp.data;
    end
  end

  assign rx_pop    = rd_rise && rd_sel && !rd_addr && rd_hit;
  assign tx_push   = wr_rise && wr_sel && !wr_addr && !tx_full;
  assign ovf_set   = wr_rise && wr_sel && !wr_addr && tx_full;
  assign flush_set = wr_rise && wr_sel && wr_addr;
  assign tx_wdata  = wr_dat;
  assign rd_value  = rd_latch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b1;
      wr_q     <= 1'b1;
      rd_sel   <= 1'b0;
      rd_addr  <= 1'b0;
      rd_hit   <= 1'b0;
      wr_sel   <= 1'b0;
      wr_addr  <= 1'b0;
      wr_dat   <= '0;
      rd_latch <= '0;
    end else begin
      rd_q     <= smp.rd_n;
      wr_q     <= smp.wr_n;
      rd_sel   <= rd_sel_d;
      rd_addr  <= rd_addr_d;
      rd_hit   <= rd_hit_d;
      wr_sel   <= wr_sel_d;
      wr_addr  <= wr_addr_d;
      wr_dat   <= wr_dat_d;
      rd_latch <= rd_latch_d;
    end
  end

  // R10: a write acts once; no two consecutive cycles push
  p_single_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |=> !tx_push);

  // R10: the returned value holds while the synchronised read strobe stays low
  p_read_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp.rd_n && !rd_q) |=> $stable(rd_value));

  // R4: a pop only happens when the FIFO holds data
  p_pop_has_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> !rx_empty);

endmodule

// File: rtl/cpubus_fifo_bridge.sv
module cpubus_fifo_bridge
  import cpubus_bridge_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_addr,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  inout  wire  [BYTE_W-1:0] bus_data,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              flush_req,
  input  logic              flush_ack,
  output logic              tx_overflow
);

  bus_sample_t       raw, smp;
  logic [SAMPLE_W-1:0] smp_bits;
  logic              rx_empty, rx_full, tx_empty, tx_full;
  logic [BYTE_W-1:0] rx_head, tx_wdata, rd_value;
  logic              rx_pop, tx_push, ovf_set, flush_set;
  logic              flush_d, ovf_d;

  assign raw = '{cs_n: bus_cs_n, addr: bus_addr, rd_n: bus_rd_n,
                 wr_n: bus_wr_n, data: bus_data};

  cpubus_sync #(.WIDTH(SAMPLE_W), .RST_VAL('1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw),
    .d_sync  (smp_bits)
  );
  assign smp = bus_sample_t'(smp_bits);

  cpubus_access u_access (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp       (smp),
    .rx_empty  (rx_empty),
    .rx_head   (rx_head),
    .tx_full   (tx_full),
    .rx_pop    (rx_pop),
    .tx_push   (tx_push),
    .tx_wdata  (tx_wdata),
    .ovf_set   (ovf_set),
    .flush_set (flush_set),
    .rd_value  (rd_value)
  );

  cpubus_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_valid),
    .push_data (rx_data),
    .pop       (rx_pop),
    .head      (rx_head),
    .empty     (rx_empty),
    .full      (rx_full)
  );

  cpubus_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (tx_push),
    .push_data (tx_wdata),
    .pop       (tx_ready),
    .head      (tx_data),
    .empty     (tx_empty),
    .full      (tx_full)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;
  assign bus_data = (!bus_cs_n && !bus_rd_n) ? rd_value : 'z;

  always_comb begin
    flush_d = flush_req;
    if (flush_ack) flush_d = 1'b0;
    if (flush_set) flush_d = 1'b1;
    ovf_d = tx_overflow || ovf_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_req   <= 1'b0;
      tx_overflow <= 1'b0;
    end else begin
      flush_req   <= flush_d;
      tx_overflow <= ovf_d;
    end
  end

  // R8: an unacknowledged flush request persists
  p_flush_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_ack) |=> flush_req);

  // R6: overflow is sticky
  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow |=> tx_overflow);

  // R5: the transmit head holds while it waits for the downstream side
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_push) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: tb/cpubus_fifo_bridge_bench.sv
`timescale 1ns/1ps
module cpubus_fifo_bridge_bench;

  localparam int DEPTH = 4;

  logic       clk, rst_n;
  logic       bus_cs_n, bus_addr, bus_rd_n, bus_wr_n;
  wire  [7:0] bus_data;
  logic [7:0] tb_dout;
  logic       tb_drv;
  logic [7:0] tx_data;
  logic       tx_valid, tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid, rx_ready;
  logic       flush_req, flush_ack, tx_overflow;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  assign bus_data = tb_drv ? tb_dout : 'z;

  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup (bus_data[i]);
  end

  cpubus_fifo_bridge #(.TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH)) u_cpubus_fifo_bridge (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_cs_n    (bus_cs_n),
    .bus_addr    (bus_addr),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .bus_data    (bus_data),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .flush_req   (flush_req),
    .flush_ack   (flush_ack),
    .tx_overflow (tx_overflow)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d, input logic cs, input int hold);
    @(negedge clk);
    bus_cs_n = cs; bus_addr = a; tb_dout = d; tb_drv = 1'b1;
    repeat (2) @(negedge clk);
    bus_wr_n = 1'b0;
    repeat (hold) @(negedge clk);
    bus_wr_n = 1'b1;
    repeat (4) @(negedge clk);
    tb_drv = 1'b0; bus_cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic a, input logic cs, input int hold,
                          output logic [7:0] v, output logic steady);
    @(negedge clk);
    bus_cs_n = cs; bus_addr = a;
    repeat (2) @(negedge clk);
    bus_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    v = bus_data;
    steady = 1'b1;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (bus_data !== v) steady = 1'b0;
    end
    bus_rd_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rx_push(input logic [7:0] v);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = v;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tx_take(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, {7'd0, tx_valid}, 8'h01);
    chk(req, tx_data, exp);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    logic       st;
    rst_n = 1'b0;
    bus_cs_n = 1'b1; bus_addr = 1'b0; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
    tb_dout = 8'h00; tb_drv = 1'b0;
    tx_ready = 1'b0; rx_data = 8'h00; rx_valid = 1'b0; flush_ack = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    chk("R5 reset tx_valid", {7'd0, tx_valid}, 8'h00);
    chk("R8 reset flush_req", {7'd0, flush_req}, 8'h00);
    chk("R6 reset overflow", {7'd0, tx_overflow}, 8'h00);
    chk("R9 reset rx_ready", {7'd0, rx_ready}, 8'h01);

    // R2: empty status
    bus_read(1'b1, 1'b0, 2, v, st);
    chk("R2 status empty", v, 8'h02);

    // R1: deselected accesses
    bus_write(1'b0, 8'h11, 1'b1, 3);
    chk("R1 write ignored", {7'd0, tx_valid}, 8'h00);
    bus_write(1'b1, 8'h11, 1'b1, 3);
    chk("R1 flush ignored", {7'd0, flush_req}, 8'h00);
    bus_read(1'b1, 1'b1, 2, v, st);
    chk("R1 bus undriven", v, 8'hFF);

    // R4: empty data read
    bus_read(1'b0, 1'b0, 2, v, st);
    chk("R4 empty read", v, 8'h00);
    bus_read(1'b1, 1'b0, 2, v, st);
    chk("R4 status after empty read", v, 8'h02);

    // R9 and R3: fill the receive FIFO
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      chk("R9 room before push", {7'd0, rx_ready}, 8'h01);
      rx_push(8'hC0 + 8'(k));
    end
    @(negedge clk);
    chk("R9 full", {7'd0, rx_ready}, 8'h00);
    rx_push(8'hEE);
    bus_read(1'b1, 1'b0, 2, v, st);
    chk("R2 status rx data", v, 8'h03);
    bus_read(1'b0, 1'b1, 2, v, st);
    chk("R1 deselected read undriven", v, 8'hFF);
    for (int k = 0; k < DEPTH; k++) begin
      bus_read(1'b0, 1'b0, 2, v, st);
      chk("R3 read order", v, 8'hC0 + 8'(k));
    end
    bus_read(1'b1, 1'b0, 2, v, st);
    chk("R3 drained status", v, 8'h02);

    // R2, R5: status sweep over transmit fill levels, then R6 overflow
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      bus_read(1'b1, 1'b0, 2, v, st);
      chk("R2 status sweep", v, (lvl < DEPTH) ? 8'h02 : 8'h00);
      if (lvl < DEPTH) bus_write(1'b0, 8'h30 + 8'(lvl), 1'b0, 3);
    end
    chk("R6 no overflow yet", {7'd0, tx_overflow}, 8'h00);
    bus_write(1'b0, 8'hEE, 1'b0, 3);
    chk("R6 overflow set", {7'd0, tx_overflow}, 8'h01);
    for (int k = 0; k < DEPTH; k++) tx_take("R5 tx order", 8'h30 + 8'(k));
    @(negedge clk);
    chk("R6 full write discarded", {7'd0, tx_valid}, 8'h00);
    chk("R6 overflow sticky", {7'd0, tx_overflow}, 8'h01);

    // R2 with receive data and transmit room
    rx_push(8'h9A);
    bus_read(1'b1, 1'b0, 2, v, st);
    chk("R2 status both", v, 8'h03);
    bus_read(1'b0, 1'b0, 2, v, st);
    chk("R3 single byte", v, 8'h9A);

    // R7: flush write
    bus_write(1'b1, 8'h5A, 1'b0, 3);
    chk("R7 flush raised", {7'd0, flush_req}, 8'h01);
    chk("R7 data ignored", {7'd0, tx_valid}, 8'h00);
    @(negedge clk); flush_ack = 1'b1;
    @(negedge clk); flush_ack = 1'b0;
    chk("R8 ack clears", {7'd0, flush_req}, 8'h00);

    // R8: flush write acted on in the same cycle as flush_ack
    @(negedge clk);
    bus_cs_n = 1'b0; bus_addr = 1'b1; tb_dout = 8'h00; tb_drv = 1'b1;
    repeat (2) @(negedge clk);
    bus_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_wr_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); flush_ack = 1'b1;
    @(negedge clk); flush_ack = 1'b0;
    chk("R8 set wins over ack", {7'd0, flush_req}, 8'h01);
    repeat (2) @(negedge clk);
    tb_drv = 1'b0; bus_cs_n = 1'b1;
    @(negedge clk); flush_ack = 1'b1;
    @(negedge clk); flush_ack = 1'b0;
    chk("R8 later ack clears", {7'd0, flush_req}, 8'h00);

    // R10: long strobes act once
    bus_write(1'b0, 8'h6C, 1'b0, 20);
    tx_take("R10 long write", 8'h6C);
    @(negedge clk);
    chk("R10 single push", {7'd0, tx_valid}, 8'h00);
    rx_push(8'hA5);
    rx_push(8'h5B);
    bus_read(1'b0, 1'b0, 20, v, st);
    chk("R10 long read value", v, 8'hA5);
    chk("R10 read stable", {7'd0, st}, 8'h01);
    bus_read(1'b0, 1'b0, 2, v, st);
    chk("R10 single pop", v, 8'h5B);

    // R4: byte arrives during a read of an empty FIFO
    fork
      bus_read(1'b0, 1'b0, 12, v, st);
      begin
        repeat (8) @(negedge clk);
        rx_push(8'h77);
      end
    join
    chk("R4 late arrival read", v, 8'h00);
    bus_read(1'b1, 1'b0, 2, v, st);
    chk("R4 late byte kept", v, 8'h03);
    bus_read(1'b0, 1'b0, 2, v, st);
    chk("R4 late byte read", v, 8'h77);

    done = 1;
    finish_run();
  end

endmodule